// File: doc/BRIEF.md
# Planar Video Read-Path Unit

This block is the read side of a video memory controller whose memory is split into four bit planes. A CPU read of one byte address brings back one byte from each plane. The block captures all four bytes in a bank of latches and answers the CPU with a single byte. The latch bank is also an output, because the write side of the controller combines CPU data with the latched bytes.

The answer byte depends on the read mode. In plane-select mode the answer is the latched byte of one chosen plane. In color-compare mode the four planes are seen as eight 4-bit pixels, and each answer bit reports whether that pixel matches a reference color. The match only looks at the color bits that a mask enables. Software sets the mode, plane choice, reference color and mask through a small indexed register file. Each register write is one 16-bit word: the register index in the low byte and the value in the high byte.

Read requests and responses are valid/ready streams with a single response slot. A new request is accepted only when the slot is empty, or when it is being emptied in the same cycle. While the consumer holds `rd_rsp_ready` low, a pending response is held unchanged and further requests wait. The configuration write port and the readback port are plain, with no handshake.

Top module: `planar_read_unit`

## Requirements
- R1: After reset, every register reads back as zero, the latch bank is zero, `rd_rsp_valid` is 0 and `rd_req_ready` is 1.
- R2: When `cfg_wr_valid` is high, bits 7:0 of `cfg_wr_word` give the register index and bits 15:8 give the data. The implemented registers and their readback are as follows. Index 2 holds the compare color in bits 3:0. Index 4 holds the plane select in bits 1:0. Index 5 is the mode byte, all 8 bits kept. Index 7 holds the care mask in bits 3:0. All other bits read back as 0.
- R3: A write to any other index changes no register and no read result. Reading back any other index gives 0.
- R4: Each accepted read request loads all four latches from `plane_bytes`, whatever the read mode. Plane k occupies bits 8k+7:8k. The latches keep their value until the next accepted request.
- R5: When bit 3 of the mode byte is 0, the response is the byte of the plane selected by register 4. The other mode bits have no effect on the read.
- R6: When bit 3 of the mode byte is 1, response bit i is 1 exactly when (pixel_i AND mask) equals (color AND mask). Pixel_i bit k is bit i of plane k.
- R7: With a care mask of 0 in color-compare mode, the response is 8'hFF for any plane data.
- R8: `rd_req_ready` equals !`rd_rsp_valid` || `rd_rsp_ready`. After a request is accepted, `rd_rsp_valid` is 1 in the next cycle. While `rd_rsp_valid` is 1 and `rd_rsp_ready` is 0, `rd_rsp_valid` and `rd_rsp_data` hold.
- R9: The response is fixed at the moment of acceptance. Register writes made while it is pending do not alter it.
- R10: In color-compare mode with mask 0111 and color 1010, a pixel 1011 gives response bit 0 and a pixel 1010 gives response bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Register write strobe |
| cfg_wr_word | input | 16 | Register write word: index in 7:0, data in 15:8 |
| cfg_rd_index | input | 8 | Register readback index |
| cfg_rd_data | output | 8 | Readback value of the indexed register |
| rd_req_valid | input | 1 | CPU read request valid |
| rd_req_ready | output | 1 | Read request can be accepted |
| plane_bytes | input | 32 | Addressed byte of each plane, plane k at bits 8k+7:8k |
| rd_rsp_valid | output | 1 | Response byte valid |
| rd_rsp_ready | input | 1 | Consumer accepts the response |
| rd_rsp_data | output | 8 | Response byte |
| latch_bytes | output | 32 | Latch bank contents for the write path |

## Verification
The hardest state to reach is a response that is stalled. That happens when a second request is waiting, the register file is rewritten, and the consumer then releases the slot. At that edge, one response must leave and the next request must be taken in, while its answer follows the new registers and the old answer ignores them. The bench holds `rd_rsp_ready` low and keeps a second request asserted. It changes the plane select during the stall and then raises ready. Around this, it sweeps all 256 color/mask pairs over plane patterns that together contain every 4-bit pixel value, and it sweeps every plane select in plane-select mode.

// File: rtl/planar_pkg.sv
package planar_pkg;
  localparam int unsigned IDX_COLOR = 2;
  localparam int unsigned IDX_PSEL  = 4;
  localparam int unsigned IDX_MODE  = 5;
  localparam int unsigned IDX_CARE  = 7;
  localparam int unsigned MODE_RD_BIT = 3;

  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_COLOR = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/planar_cfg_regs.sv
module planar_cfg_regs
  import planar_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [2*BYTE_W-1:0]        wr_word,
  input  logic [BYTE_W-1:0]          rd_index,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [PLANES-1:0]          color,
  output logic [PLANES-1:0]          care,
  output logic [$clog2(PLANES)-1:0]  psel,
  output rd_mode_e                   mode
);
  localparam int SEL_W = $clog2(PLANES);

  logic [BYTE_W-1:0] wr_idx, wr_dat;
  logic [PLANES-1:0] color_q, care_q;
  logic [SEL_W-1:0]  psel_q;
  logic [BYTE_W-1:0] mode_q;
  logic              hit_color, hit_psel, hit_mode, hit_care;

  assign wr_idx = wr_word[BYTE_W-1:0];
  assign wr_dat = wr_word[2*BYTE_W-1:BYTE_W];

  assign hit_color = wr_valid && (wr_idx == BYTE_W'(IDX_COLOR));
  assign hit_psel  = wr_valid && (wr_idx == BYTE_W'(IDX_PSEL));
  assign hit_mode  = wr_valid && (wr_idx == BYTE_W'(IDX_MODE));
  assign hit_care  = wr_valid && (wr_idx == BYTE_W'(IDX_CARE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color_q <= '0;
      care_q  <= '0;
      psel_q  <= '0;
      mode_q  <= '0;
    end else begin
      if (hit_color) color_q <= wr_dat[PLANES-1:0];
      if (hit_psel)  psel_q  <= wr_dat[SEL_W-1:0];
      if (hit_mode)  mode_q  <= wr_dat;
      if (hit_care)  care_q  <= wr_dat[PLANES-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_index == BYTE_W'(IDX_COLOR))     rd_data = {{(BYTE_W-PLANES){1'b0}}, color_q};
    else if (rd_index == BYTE_W'(IDX_PSEL)) rd_data = {{(BYTE_W-SEL_W){1'b0}}, psel_q};
    else if (rd_index == BYTE_W'(IDX_MODE)) rd_data = mode_q;
    else if (rd_index == BYTE_W'(IDX_CARE)) rd_data = {{(BYTE_W-PLANES){1'b0}}, care_q};
  end

  assign color = color_q;
  assign care  = care_q;
  assign psel  = psel_q;
  assign mode  = rd_mode_e'(mode_q[MODE_RD_BIT]);

  // R2: registers move only on a write strobe
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> ($stable(color_q) && $stable(care_q) && $stable(psel_q) && $stable(mode_q)));

  // R3: writes to unimplemented indices leave all registers untouched
  a_r3_ignore_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !hit_color && !hit_psel && !hit_mode && !hit_care)
    |=> ($stable(color_q) && $stable(care_q) && $stable(psel_q) && $stable(mode_q)));
endmodule

// File: rtl/planar_latch_bank.sv
module planar_latch_bank #(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [PLANES*BYTE_W-1:0] plane_in,
  output logic [PLANES*BYTE_W-1:0] latch_q
);
  for (genvar k = 0; k < PLANES; k++) begin : g_plane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    byte_q <= '0;
      else if (load) byte_q <= plane_in[k*BYTE_W +: BYTE_W];
    end
    assign latch_q[k*BYTE_W +: BYTE_W] = byte_q;
  end

  // R4: latches hold between accepted reads
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(latch_q));

  // R4: an accepted read captures every plane
  a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (latch_q == $past(plane_in)));
endmodule

// File: rtl/planar_color_match.sv
module planar_color_match #(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic [PLANES*BYTE_W-1:0] planes,
  input  logic [PLANES-1:0]        color,
  input  logic [PLANES-1:0]        care,
  output logic [BYTE_W-1:0]        match
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_pix
    logic [PLANES-1:0] pix;
    for (genvar k = 0; k < PLANES; k++) begin : g_bit
      assign pix[k] = planes[k*BYTE_W + i];
    end
    assign match[i] = ((pix & care) == (color & care));
  end

  // R7: an empty care mask matches every pixel
  always_comb begin
    if (care == '0) a_r7_all_match: assert (match == '1);
  end
endmodule

// File: rtl/planar_read_mux.sv
module planar_read_mux
  import planar_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic [PLANES*BYTE_W-1:0]   planes,
  input  logic [$clog2(PLANES)-1:0]  psel,
  input  rd_mode_e                   mode,
  input  logic [BYTE_W-1:0]          match,
  output logic [BYTE_W-1:0]          result
);
  logic [BYTE_W-1:0] plane_arr [PLANES];

  for (genvar k = 0; k < PLANES; k++) begin : g_split
    assign plane_arr[k] = planes[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    unique case (mode)
      RD_COLOR: result = match;
      default:  result = plane_arr[psel];
    endcase
  end
endmodule

// File: rtl/planar_read_unit.sv
module planar_read_unit
  import planar_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr_valid,
  input  logic [2*BYTE_W-1:0]      cfg_wr_word,
  input  logic [BYTE_W-1:0]        cfg_rd_index,
  output logic [BYTE_W-1:0]        cfg_rd_data,
  input  logic                     rd_req_valid,
  output logic                     rd_req_ready,
  input  logic [PLANES*BYTE_W-1:0] plane_bytes,
  output logic                     rd_rsp_valid,
  input  logic                     rd_rsp_ready,
  output logic [BYTE_W-1:0]        rd_rsp_data,
  output logic [PLANES*BYTE_W-1:0] latch_bytes
);
  localparam int SEL_W = $clog2(PLANES);

  logic [PLANES-1:0] color, care;
  logic [SEL_W-1:0]  psel;
  rd_mode_e          mode;
  logic [BYTE_W-1:0] match, result;
  logic              accept;
  logic              rsp_valid_q;
  logic [BYTE_W-1:0] rsp_data_q;

  planar_cfg_regs #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(cfg_wr_valid), .wr_word(cfg_wr_word),
    .rd_index(cfg_rd_index), .rd_data(cfg_rd_data),
    .color(color), .care(care), .psel(psel), .mode(mode)
  );

  planar_latch_bank #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .plane_in(plane_bytes), .latch_q(latch_bytes)
  );

  planar_color_match #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_match (
    .planes(plane_bytes), .color(color), .care(care), .match(match)
  );

  planar_read_mux #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_mux (
    .planes(plane_bytes), .psel(psel), .mode(mode),
    .match(match), .result(result)
  );

  assign rd_req_ready = !rsp_valid_q || rd_rsp_ready;
  assign accept       = rd_req_valid && rd_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= result;
    end else if (rd_rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rd_rsp_valid = rsp_valid_q;
  assign rd_rsp_data  = rsp_data_q;

  // R8: an accepted request produces a response next cycle
  a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> rd_rsp_valid);

  // R8: a stalled response is held
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_data)));

  // R4: the latch bank and the response are loaded together
  a_r4_latch_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rsp_valid |=> ($stable(latch_bytes) || rd_rsp_valid));
endmodule

// File: tb/tb_planar_read_unit.sv
`timescale 1ns/1ps
module tb_planar_read_unit;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_valid;
  logic [15:0] cfg_wr_word;
  logic [7:0]  cfg_rd_index;
  logic [7:0]  cfg_rd_data;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [31:0] plane_bytes;
  logic        rd_rsp_valid;
  logic        rd_rsp_ready;
  logic [7:0]  rd_rsp_data;
  logic [31:0] latch_bytes;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  planar_read_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_word(cfg_wr_word),
    .cfg_rd_index(cfg_rd_index), .cfg_rd_data(cfg_rd_data),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .plane_bytes(plane_bytes),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .latch_bytes(latch_bytes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] dat);
    @(negedge clk);
    cfg_wr_valid = 1'b1;
    cfg_wr_word  = {dat, idx};
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] idx, output logic [7:0] val);
    cfg_rd_index = idx;
    #1;
    val = cfg_rd_data;
  endtask

  // issues one read; returns at the negedge after acceptance
  task automatic do_read(input logic [31:0] p);
    @(negedge clk);
    rd_req_valid = 1'b1;
    plane_bytes  = p;
    @(negedge clk);
    rd_req_valid = 1'b0;
  endtask

  function automatic logic [7:0] exp_color(input logic [31:0] p, input logic [3:0] c,
                                           input logic [3:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic [3:0] px;
      for (int k = 0; k < 4; k++) px[k] = p[k*8+i];
      r[i] = ((px & m) == (c & m));
    end
    return r;
  endfunction

  function automatic logic [31:0] pix_pattern(input int base);
    logic [31:0] p;
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++)
        p[k*8+i] = ((base + i) >> k) & 1;
    return p;
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] pats [4];
    logic [31:0] pa, pb;

    rst_n = 1'b0; cfg_wr_valid = 1'b0; cfg_wr_word = '0; cfg_rd_index = '0;
    rd_req_valid = 1'b0; plane_bytes = '0; rd_rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", {31'd0, rd_rsp_valid}, 32'd0);
    check("R1 req_ready", {31'd0, rd_req_ready}, 32'd1);
    check("R1 latches", latch_bytes, 32'd0);
    for (int idx = 0; idx < 8; idx++) begin
      cfg_read(8'(idx), v);
      check("R1 register zero", {24'd0, v}, 32'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 write and readback with field widths
    cfg_write(8'd2, 8'hFB); cfg_write(8'd4, 8'hFE);
    cfg_write(8'd5, 8'hA6); cfg_write(8'd7, 8'h3D);
    cfg_read(8'd2, v); check("R2 color readback", {24'd0, v}, 32'h0B);
    cfg_read(8'd4, v); check("R2 psel readback", {24'd0, v}, 32'h02);
    cfg_read(8'd5, v); check("R2 mode readback", {24'd0, v}, 32'hA6);
    cfg_read(8'd7, v); check("R2 care readback", {24'd0, v}, 32'h0D);

    // R3 unimplemented indices: no effect, read zero
    cfg_write(8'd0, 8'hFF); cfg_write(8'd3, 8'hFF); cfg_write(8'd6, 8'hFF);
    cfg_write(8'h82, 8'h00); cfg_write(8'h84, 8'h01); cfg_write(8'hFF, 8'h08);
    cfg_read(8'd2, v); check("R3 color untouched", {24'd0, v}, 32'h0B);
    cfg_read(8'd4, v); check("R3 psel untouched", {24'd0, v}, 32'h02);
    cfg_read(8'd5, v); check("R3 mode untouched", {24'd0, v}, 32'hA6);
    cfg_read(8'd7, v); check("R3 care untouched", {24'd0, v}, 32'h0D);
    cfg_read(8'd3, v); check("R3 unknown reads zero", {24'd0, v}, 32'd0);
    cfg_read(8'h82, v); check("R3 alias reads zero", {24'd0, v}, 32'd0);
    // mode byte A6 has bit 3 = 0, psel 2: read result unchanged by the junk writes
    do_read(32'h44332211);
    check("R3 read result after junk writes", {24'd0, rd_rsp_data}, 32'h33);

    pats[0] = pix_pattern(0);
    pats[1] = pix_pattern(8);
    pats[2] = 32'hA53CF00F;
    pats[3] = 32'h12345678;

    // R5 plane-select sweep, other mode bits set
    cfg_write(8'd5, 8'hF7);
    for (int s = 0; s < 4; s++) begin
      cfg_write(8'd4, 8'(s));
      for (int j = 0; j < 4; j++) begin
        do_read(pats[j]);
        check("R5 plane select", {24'd0, rd_rsp_data}, {24'd0, pats[j][s*8 +: 8]});
        check("R4 latch load", latch_bytes, pats[j]);
      end
    end

    // R6/R7 exhaustive color and mask sweep
    cfg_write(8'd5, 8'h08);
    for (int c = 0; c < 16; c++) begin
      cfg_write(8'd2, 8'(c));
      for (int m = 0; m < 16; m++) begin
        cfg_write(8'd7, 8'(m));
        for (int j = 0; j < 4; j++) begin
          do_read(pats[j]);
          if (m == 0)
            check("R7 empty mask all match", {24'd0, rd_rsp_data}, 32'hFF);
          else
            check("R6 color compare", {24'd0, rd_rsp_data},
                  {24'd0, exp_color(pats[j], 4'(c), 4'(m))});
        end
      end
    end

    // R10 worked case: pixel0 = 1011, pixel1 = 1010
    cfg_write(8'd2, 8'h0A); cfg_write(8'd7, 8'h07);
    do_read({8'h03, 8'h00, 8'h03, 8'h01});
    check("R10 worked case", {24'd0, rd_rsp_data}, 32'h02);
    check("R4 latch in color mode", latch_bytes, {8'h03, 8'h00, 8'h03, 8'h01});

    // R4 hold across idle cycles and register writes
    cfg_write(8'd5, 8'h00);
    repeat (5) @(negedge clk);
    check("R4 latch hold", latch_bytes, {8'h03, 8'h00, 8'h03, 8'h01});

    // R8/R9 stall with a waiting request and a register change
    pa = 32'hDDCCBBAA; pb = 32'h44332211;
    cfg_write(8'd4, 8'd1);
    rd_rsp_ready = 1'b0;
    do_read(pa);
    check("R8 rsp valid after accept", {31'd0, rd_rsp_valid}, 32'd1);
    check("R5 stalled data", {24'd0, rd_rsp_data}, 32'hBB);
    rd_req_valid = 1'b1; plane_bytes = pb;
    #1;
    check("R8 not ready while stalled", {31'd0, rd_req_ready}, 32'd0);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_word = {8'd3, 8'd4};
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    @(negedge clk);
    check("R8 still valid", {31'd0, rd_rsp_valid}, 32'd1);
    check("R9 data unchanged by write", {24'd0, rd_rsp_data}, 32'hBB);
    check("R4 waiting request not latched", latch_bytes, pa);
    rd_rsp_ready = 1'b1;
    #1;
    check("R8 ready when consumer ready", {31'd0, rd_req_ready}, 32'd1);
    @(negedge clk);
    rd_req_valid = 1'b0;
    check("R8 back-to-back valid", {31'd0, rd_rsp_valid}, 32'd1);
    check("R5 new select applies", {24'd0, rd_rsp_data}, 32'h44);
    check("R4 second latch", latch_bytes, pb);
    @(negedge clk);
    check("R8 drained", {31'd0, rd_rsp_valid}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule